// File: doc/BRIEF.md
# Ratio-Coded Single-Wire Command Receiver

This block listens to one open-drain control line and turns short serial commands into a small register write. The host encodes every bit in the proportion between the time the line spends low and the time it spends high. The bit period runs from one falling edge to the next, so the receiver needs no agreed bit rate. It only compares the two phase durations it measures in clock cycles.

A command is two bytes, most significant bit first. The first byte must equal the device address; the second carries an acknowledge-request flag, a 2-bit register selector and a 5-bit value. A byte ends when the line rests high for an end-of-stream interval. When the whole command is accepted and the host asked for it, the receiver pulls the line low for a fixed time as a handshake. The pull-down enable drives an external open-drain transistor. The host must release the line for the pulse to be seen.

Top module: `ratio_cmd_rx`

## Requirements
- R1: After reset `data_val` is 5'b11111 (full scale), `reg_addr` is 2'b00, and `data_vld` and `pull_en` are 0.
- R2: A bit whose high phase lasts at least twice its low phase is decoded as 1.
- R3: A bit whose low phase lasts at least twice its high phase is decoded as 0. The last bit of a byte has a high phase that runs into end-of-stream, so it is instead decoded as 0 when twice its low time is at least the preceding bit period, and as 1 otherwise.
- R4: A bit with neither phase at least twice the other marks the command bad. A bad command changes no output and raises no acknowledge.
- R5: The first byte, sent MSB first, must equal `DEV_ADDR` (default 8'h72). On any other value the command changes no output and raises no acknowledge.
- R6: Second byte bit 7 is the acknowledge request, bits 6:5 the register selector and bits 4:0 the value. A good command copies the selector to `reg_addr`. Only when the selector is 2'b00 does it load `data_val` and pulse `data_vld` high for exactly one cycle.
- R7: When the acknowledge request is set and the command is good, `pull_en` rises `ACK_DLY_CYC` cycles after the strobe cycle and stays high for exactly `ACK_LEN_CYC` cycles. With the request clear, `pull_en` stays low.
- R8: A byte closes when the line stays high for `EOS_CYC` cycles. A byte holding other than 8 bits discards the command.
- R9: A command starts only on a falling edge preceded by at least `START_CYC` cycles of high line. A line that is already resting high counts as the start. The line must also rest high that long again after an acknowledge pulse.
- R10: The same command decodes to the same result at bit periods differing by more than five times.
- R11: If no second byte begins within `GAP_CYC` cycles after the first byte closes, the first byte is dropped. The next falling edge after a start condition then begins a new address byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_in | input | 1 | Level read back from the shared control line |
| data_val | output | 5 | Last value committed to register 00 |
| data_vld | output | 1 | One-cycle strobe when `data_val` is loaded |
| reg_addr | output | 2 | Register selector of the last good command |
| pull_en | output | 1 | Enable for the external open-drain pull-down |

## Verification
Errors inside the block show up at the ports only at the end of a command. A misclassified bit, a wrong bit count or a stale address register appears as a wrong `data_val` or `reg_addr`, or a missing or extra strobe, within a few cycles of the end-of-stream interval that closes the second byte. A wrong frame state can also hide until the next command, which then lands one byte out of step. For this reason every scenario is followed by a fresh good command, or by a check that the earlier value still holds. Acknowledge timing faults appear as a wrong count of cycles with `pull_en` high, measured as soon as the pulse ends.

// File: rtl/rcrx_pkg.sv
`timescale 1ns/1ps
package rcrx_pkg;

   localparam int unsigned BYTE_BITS = 8;
   localparam int unsigned VAL_W     = 5;
   localparam int unsigned SEL_W     = 2;
   localparam int unsigned NBIT_W    = $clog2(2 * BYTE_BITS);

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_GAP,
      ST_DATA,
      ST_ACK_WAIT,
      ST_ACK_PULL
   } rcrx_state_e;

   typedef struct packed {
      logic             ack_req;
      logic [SEL_W-1:0] sel;
      logic [VAL_W-1:0] val;
   } rcrx_cmd_t;

endpackage

// File: rtl/rcrx_sync.sv
`timescale 1ns/1ps
module rcrx_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   logic [STAGES-1:0] chain;

   generate
      if (STAGES == 1) begin : g_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '0;
            else        chain <= d;
         end
      end else begin : g_chain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '0;
            else        chain <= {chain[STAGES-2:0], d};
         end
      end
   endgenerate

   assign q = chain[STAGES-1];

endmodule

// File: rtl/rcrx_phase_timer.sv
`timescale 1ns/1ps
module rcrx_phase_timer #(
   parameter int unsigned CNT_W   = 18,
   parameter int unsigned EOS_CYC = 100000
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             lvl,
   output logic             fall,
   output logic             eos,
   output logic [CNT_W-1:0] low_cnt,
   output logic [CNT_W-1:0] high_cnt
);

   localparam logic [CNT_W-1:0] CNT_MAX  = {CNT_W{1'b1}};
   localparam logic [CNT_W-1:0] EOS_LAST = CNT_W'(EOS_CYC - 1);

   logic lvl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lvl_q <= 1'b0;
      else        lvl_q <= lvl;
   end

   assign fall = lvl_q & ~lvl;
   assign eos  = lvl & (high_cnt == EOS_LAST);

   // low phase counts from the falling edge, high phase from the rise
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         low_cnt  <= '0;
         high_cnt <= '0;
      end else if (fall) begin
         low_cnt  <= CNT_W'(1);
         high_cnt <= '0;
      end else if (!lvl) begin
         if (low_cnt != CNT_MAX) low_cnt <= low_cnt + 1'b1;
      end else begin
         if (high_cnt != CNT_MAX) high_cnt <= high_cnt + 1'b1;
      end
   end

   assert_eos_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      eos |-> $past(lvl));

endmodule

// File: rtl/rcrx_frame_fsm.sv
`timescale 1ns/1ps
module rcrx_frame_fsm
   import rcrx_pkg::*;
#(
   parameter int unsigned CNT_W       = 18,
   parameter int unsigned START_CYC   = 500,
   parameter int unsigned GAP_CYC     = 200000,
   parameter int unsigned ACK_DLY_CYC = 500,
   parameter int unsigned ACK_LEN_CYC = 128000,
   parameter logic [7:0]  DEV_ADDR    = 8'h72
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             lvl,
   input  logic             fall,
   input  logic             eos,
   input  logic [CNT_W-1:0] low_cnt,
   input  logic [CNT_W-1:0] high_cnt,
   output logic [VAL_W-1:0] data_val,
   output logic             data_vld,
   output logic [SEL_W-1:0] reg_addr,
   output logic             pull_en
);

   localparam int unsigned ACK_MAX = (ACK_DLY_CYC > ACK_LEN_CYC) ? ACK_DLY_CYC : ACK_LEN_CYC;
   localparam int unsigned ACK_W   = $clog2(ACK_MAX + 1);
   localparam int unsigned GAP_W   = $clog2(GAP_CYC + 1);
   localparam int unsigned PER_W   = CNT_W + 1;
   localparam logic [NBIT_W-1:0] NB_FULL = NBIT_W'(BYTE_BITS);
   localparam logic [NBIT_W-1:0] NB_MAX  = {NBIT_W{1'b1}};

   rcrx_state_e          state;
   logic [BYTE_BITS-1:0] shreg;
   logic [BYTE_BITS-1:0] addr_q;
   logic [NBIT_W-1:0]    nbits;
   logic [PER_W-1:0]     prev_per;
   logic [GAP_W-1:0]     gap_cnt;
   logic [ACK_W-1:0]     ack_cnt;
   logic                 bad;
   logic                 armed;
   logic                 pull_q;

   // ---------------- bit classification ----------------
   logic [PER_W-1:0]     lo_x2, hi_x2, lo_w, hi_w, period;
   logic                 is_one, is_zero, is_amb, tail_bit;
   logic [NBIT_W-1:0]    nb_inc;
   logic [BYTE_BITS-1:0] sh_fall, sh_tail;
   rcrx_cmd_t            cmd;
   logic                 frame_ok;

   always_comb begin
      lo_w     = {1'b0, low_cnt};
      hi_w     = {1'b0, high_cnt};
      lo_x2    = {low_cnt, 1'b0};
      hi_x2    = {high_cnt, 1'b0};
      period   = lo_w + hi_w;
      is_one   = hi_w >= lo_x2;
      is_zero  = lo_w >= hi_x2;
      is_amb   = !is_one && !is_zero;
      tail_bit = !(lo_x2 >= prev_per);
      nb_inc   = (nbits == NB_MAX) ? NB_MAX : nbits + 1'b1;
      sh_fall  = {shreg[BYTE_BITS-2:0], is_one};
      sh_tail  = {shreg[BYTE_BITS-2:0], tail_bit};
      cmd      = rcrx_cmd_t'(sh_tail);
      frame_ok = !bad && (nb_inc == NB_FULL) && (addr_q == DEV_ADDR);
   end

   // ---------------- start-condition tracking ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         armed <= 1'b0;
      else if (state == ST_ACK_WAIT || state == ST_ACK_PULL)
         armed <= 1'b0;
      else if (lvl && high_cnt >= CNT_W'(START_CYC - 1))
         armed <= 1'b1;
      else if (fall)
         armed <= 1'b0;
   end

   // ---------------- frame sequencing ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         shreg    <= '0;
         addr_q   <= '0;
         nbits    <= '0;
         prev_per <= '0;
         gap_cnt  <= '0;
         ack_cnt  <= '0;
         bad      <= 1'b0;
         pull_q   <= 1'b0;
         data_val <= '1;
         data_vld <= 1'b0;
         reg_addr <= '0;
      end else begin
         data_vld <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (fall && armed) begin
                  state    <= ST_ADDR;
                  shreg    <= '0;
                  nbits    <= '0;
                  prev_per <= '0;
                  bad      <= 1'b0;
               end
            end
            ST_ADDR, ST_DATA: begin
               if (fall) begin
                  shreg    <= sh_fall;
                  nbits    <= nb_inc;
                  prev_per <= period;
                  if (is_amb) bad <= 1'b1;
               end else if (eos) begin
                  if (state == ST_ADDR) begin
                     if (nb_inc == NB_FULL) begin
                        addr_q  <= sh_tail;
                        gap_cnt <= '0;
                        state   <= ST_GAP;
                     end else begin
                        state <= ST_IDLE;
                     end
                  end else if (frame_ok) begin
                     reg_addr <= cmd.sel;
                     if (cmd.sel == '0) begin
                        data_val <= cmd.val;
                        data_vld <= 1'b1;
                     end
                     if (cmd.ack_req) begin
                        ack_cnt <= '0;
                        state   <= ST_ACK_WAIT;
                     end else begin
                        state <= ST_IDLE;
                     end
                  end else begin
                     state <= ST_IDLE;
                  end
               end
            end
            ST_GAP: begin
               if (fall) begin
                  state    <= ST_DATA;
                  shreg    <= '0;
                  nbits    <= '0;
                  prev_per <= '0;
               end else if (gap_cnt == GAP_W'(GAP_CYC - 1)) begin
                  state <= ST_IDLE;
               end else begin
                  gap_cnt <= gap_cnt + 1'b1;
               end
            end
            ST_ACK_WAIT: begin
               if (ack_cnt == ACK_W'(ACK_DLY_CYC - 1)) begin
                  ack_cnt <= '0;
                  pull_q  <= 1'b1;
                  state   <= ST_ACK_PULL;
               end else begin
                  ack_cnt <= ack_cnt + 1'b1;
               end
            end
            ST_ACK_PULL: begin
               if (ack_cnt == ACK_W'(ACK_LEN_CYC - 1)) begin
                  pull_q <= 1'b0;
                  state  <= ST_IDLE;
               end else begin
                  ack_cnt <= ack_cnt + 1'b1;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign pull_en = pull_q;

   // ---------------- assertions ----------------
   assert_strobe_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
      data_vld |=> !data_vld);

   assert_commit_sel_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      data_vld |-> (reg_addr == '0));

   assert_no_pull_at_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
      data_vld |-> !pull_en);

   assert_pull_ends_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (pull_en && state == ST_ACK_PULL && ack_cnt == ACK_W'(ACK_LEN_CYC - 1)) |=> !pull_en);

endmodule

// File: rtl/ratio_cmd_rx.sv
`timescale 1ns/1ps
module ratio_cmd_rx
   import rcrx_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned CNT_W       = 18,
   parameter int unsigned START_CYC   = 500,
   parameter int unsigned EOS_CYC     = 100000,
   parameter int unsigned GAP_CYC     = 200000,
   parameter int unsigned ACK_DLY_CYC = 500,
   parameter int unsigned ACK_LEN_CYC = 128000,
   parameter logic [7:0]  DEV_ADDR    = 8'h72
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       line_in,
   output logic [4:0] data_val,
   output logic       data_vld,
   output logic [1:0] reg_addr,
   output logic       pull_en
);

   // elaboration-time parameter checks
   if (SYNC_STAGES < 1) begin : g_chk_sync
      $error("SYNC_STAGES must be at least 1");
   end
   if (START_CYC < 2 || START_CYC >= EOS_CYC) begin : g_chk_start
      $error("START_CYC must lie in [2, EOS_CYC)");
   end
   if (EOS_CYC >= (64'd1 << CNT_W)) begin : g_chk_eos
      $error("EOS_CYC must fit below the saturating phase counter");
   end
   if (GAP_CYC < 1 || ACK_DLY_CYC < 1 || ACK_LEN_CYC < 1) begin : g_chk_tmr
      $error("GAP_CYC, ACK_DLY_CYC and ACK_LEN_CYC must be at least 1");
   end
   if (VAL_W != 5 || SEL_W != 2) begin : g_chk_fmt
      $error("port widths assume a 5-bit value and a 2-bit selector");
   end

   logic             lvl, fall, eos;
   logic [CNT_W-1:0] low_cnt, high_cnt;

   rcrx_sync #(
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (line_in),
      .q     (lvl)
   );

   rcrx_phase_timer #(
      .CNT_W   (CNT_W),
      .EOS_CYC (EOS_CYC)
   ) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .lvl      (lvl),
      .fall     (fall),
      .eos      (eos),
      .low_cnt  (low_cnt),
      .high_cnt (high_cnt)
   );

   rcrx_frame_fsm #(
      .CNT_W       (CNT_W),
      .START_CYC   (START_CYC),
      .GAP_CYC     (GAP_CYC),
      .ACK_DLY_CYC (ACK_DLY_CYC),
      .ACK_LEN_CYC (ACK_LEN_CYC),
      .DEV_ADDR    (DEV_ADDR)
   ) u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .lvl      (lvl),
      .fall     (fall),
      .eos      (eos),
      .low_cnt  (low_cnt),
      .high_cnt (high_cnt),
      .data_val (data_val),
      .data_vld (data_vld),
      .reg_addr (reg_addr),
      .pull_en  (pull_en)
   );

endmodule

// File: tb/ratio_cmd_rx_tb.sv
`timescale 1ns/1ps
module ratio_cmd_rx_tb_top;

   localparam int START  = 30;
   localparam int EOS    = 500;
   localparam int GAP    = 1500;
   localparam int ADLY   = 10;
   localparam int ALEN   = 200;
   localparam int SETTLE = 1700;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       drv = 1'b0;
   logic       line_in;
   logic [4:0] data_val;
   logic       data_vld;
   logic [1:0] reg_addr;
   logic       pull_en;

   int n_chk = 0;
   int n_bad = 0;
   int vld_seen = 0;
   int pull_seen = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   // open-drain line: master releases (1) or pulls low; device may pull low
   assign line_in = drv & ~pull_en;

   ratio_cmd_rx #(
      .SYNC_STAGES (2),
      .CNT_W       (12),
      .START_CYC   (START),
      .EOS_CYC     (EOS),
      .GAP_CYC     (GAP),
      .ACK_DLY_CYC (ADLY),
      .ACK_LEN_CYC (ALEN),
      .DEV_ADDR    (8'h72)
   ) dut_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .line_in  (line_in),
      .data_val (data_val),
      .data_vld (data_vld),
      .reg_addr (reg_addr),
      .pull_en  (pull_en)
   );

   always @(negedge clk) begin
      if (rst_n) begin
         if (data_vld) vld_seen++;
         if (pull_en)  pull_seen++;
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic hold(input logic v, input int n);
      drv = v;
      repeat (n) @(negedge clk);
   endtask

   // amb_pos selects a bit index sent with equal phases (-1: none)
   task automatic send_byte(input logic [15:0] b, input int nb, input bit slow, input int amb_pos);
      for (int i = nb - 1; i >= 0; i--) begin
         int lo;
         int hi;
         if (i == amb_pos) begin
            lo = 40; hi = 40;
         end else if (b[i]) begin
            lo = slow ? 100 : 20; hi = slow ? 300 : 50;
         end else begin
            lo = slow ? 300 : 50; hi = slow ? 100 : 20;
         end
         hold(1'b0, lo);
         if (i == 0) hold(1'b1, EOS + 20);
         else        hold(1'b1, hi);
      end
   endtask

   task automatic send_frame(input logic [7:0] a, input logic [7:0] d, input bit slow, input int amb_pos);
      send_byte({8'h00, a}, 8, slow, -1);
      send_byte({8'h00, d}, 8, slow, amb_pos);
      hold(1'b1, SETTLE);
   endtask

   task automatic expect_result(input string req, input int v0, input int p0,
                                input int exp_vld, input int exp_pull,
                                input int exp_val, input int exp_sel);
      chk({req, " strobes"}, vld_seen - v0, exp_vld);
      chk({req, " pull cycles"}, pull_seen - p0, exp_pull);
      chk({req, " data_val"}, int'(data_val), exp_val);
      chk({req, " reg_addr"}, int'(reg_addr), exp_sel);
   endtask

   task automatic t_reset();
      chk("R1 data_val", int'(data_val), 31);
      chk("R1 reg_addr", int'(reg_addr), 0);
      chk("R1 data_vld", int'(data_vld), 0);
      chk("R1 pull_en",  int'(pull_en), 0);
   endtask

   task automatic t_unarmed();
      int v0 = vld_seen; int p0 = pull_seen;
      hold(1'b1, 5);
      send_frame(8'h72, 8'h85, 1'b0, -1);
      expect_result("R9 unarmed start", v0, p0, 0, 0, 31, 0);
   endtask

   task automatic t_fast_plain();
      int v0 = vld_seen; int p0 = pull_seen;
      send_frame(8'h72, 8'h16, 1'b0, -1);
      expect_result("R2 R3 R5 fast commit", v0, p0, 1, 0, 22, 0);
   endtask

   task automatic t_fast_ack();
      int v0 = vld_seen; int p0 = pull_seen;
      send_frame(8'h72, 8'h89, 1'b0, -1);
      expect_result("R7 ack fast", v0, p0, 1, ALEN, 9, 0);
   endtask

   task automatic t_slow_ack();
      int v0 = vld_seen; int p0 = pull_seen;
      send_frame(8'h72, 8'h85, 1'b1, -1);
      expect_result("R10 slow rate", v0, p0, 1, ALEN, 5, 0);
   endtask

   task automatic t_wrong_addr();
      int v0 = vld_seen; int p0 = pull_seen;
      send_frame(8'h73, 8'h8E, 1'b0, -1);
      expect_result("R5 address mismatch", v0, p0, 0, 0, 5, 0);
   endtask

   task automatic t_other_sel();
      int v0 = vld_seen; int p0 = pull_seen;
      send_frame(8'h72, 8'h3F, 1'b0, -1);
      expect_result("R6 selector 01", v0, p0, 0, 0, 5, 1);
   endtask

   task automatic t_ambiguous();
      int v0 = vld_seen; int p0 = pull_seen;
      send_frame(8'h72, 8'h8C, 1'b0, 3);
      expect_result("R4 ambiguous bit", v0, p0, 0, 0, 5, 1);
   endtask

   task automatic t_long_byte();
      int v0 = vld_seen; int p0 = pull_seen;
      send_byte(16'h0072, 8, 1'b0, -1);
      send_byte(16'h0115, 9, 1'b0, -1);
      hold(1'b1, SETTLE);
      expect_result("R8 nine-bit byte", v0, p0, 0, 0, 5, 1);
   endtask

   task automatic t_short_byte();
      int v0 = vld_seen; int p0 = pull_seen;
      send_byte(16'h0039, 7, 1'b0, -1);
      send_byte(16'h0083, 8, 1'b0, -1);
      hold(1'b1, SETTLE);
      expect_result("R8 seven-bit byte", v0, p0, 0, 0, 5, 1);
   endtask

   task automatic t_gap_timeout();
      int v0 = vld_seen; int p0 = pull_seen;
      send_byte(16'h0072, 8, 1'b0, -1);
      hold(1'b1, SETTLE);
      send_frame(8'h72, 8'h0C, 1'b0, -1);
      expect_result("R11 gap timeout", v0, p0, 1, 0, 12, 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      drv   = 1'b0;
      rst_n = 1'b0;
      repeat (5) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      t_unarmed();
      t_fast_plain();
      t_fast_ack();
      t_slow_ack();
      t_wrong_addr();
      t_other_sel();
      t_ambiguous();
      t_long_byte();
      t_short_byte();
      t_gap_timeout();
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule